// File: doc/BRIEF.md
# Multi-drop text command interpreter

This block sits behind a serial receiver on a bus that many boards share. It takes one received byte per cycle and splits each text line into a three-letter keyword and a series of decimal numbers. When a line is well formed and its first number equals the board's own 8-bit jumper address, the block carries out the command. There are three commands. A presence query sends back a short text line with the board address and a fixed firmware version. A threshold write pulses a strobe carrying a channel and a value in millivolts. A delay write pulses a second strobe carrying a channel and a step count.

Each line is checked as it streams in. No line buffer is kept. Every number is built up in place as the digits arrive. The decision on a line is taken in the cycle that its terminator arrives. Lines that are malformed, out of range or addressed to another board produce no strobe and no reply, so the shared line stays quiet. The reply goes out one character at a time over a valid/ready handshake toward the serial transmitter.

Top module: `cmd_line_parser`

## Requirements
- R1: After reset, `dac_wr`, `delay_wr` and `tx_valid` are low.
- R2: A line is a keyword followed by decimal arguments. One or more spaces (0x20) separate the tokens. The line ends on carriage return (0x0D) or line feed (0x0A). Leading zeros in a number are allowed, and an empty line does nothing.
- R3: `dac B C V`, with B equal to `board_addr`, C in 0..7 and V in 0..4095, raises `dac_wr` for exactly one cycle. This happens on the clock after the terminator byte is taken, with `wr_chan`=C and `wr_value`=V.
- R4: `del B C V`, with B equal to `board_addr`, C in 0..7 and V in 0..255, raises `delay_wr` for exactly one cycle. The timing is the same as R3, with `wr_chan`=C and `wr_value`=V.
- R5: A command whose board number differs from `board_addr` gives no strobe and no reply byte.
- R6: A threshold or delay command with a channel above 7, a threshold value above 4095 or a delay value above 255 is dropped with no strobe.
- R7: A line is dropped with no strobe and no reply if it has any of these faults: a keyword other than the lowercase `ver`, `dac` or `del`; a keyword that is not exactly three characters; a non-digit character in an argument; or the wrong argument count (one for `ver`, three for the writes).
- R8: A number accumulates as value*10+digit and saturates at 65535, so it never wraps. For example, 65541 must not be read as 5.
- R9: `ver B`, with B equal to `board_addr`, makes the block send the bytes `ver`, a space, the address in decimal, a space, the firmware version in decimal, then 0x0D 0x0A. Both numbers are written without leading zeros. A `ver` line that arrives while a reply is still being sent is ignored.
- R10: A reply byte moves on only when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | rx_data holds a new character this cycle |
| board_addr | input | 8 | Jumper address of this board |
| dac_wr | output | 1 | One-cycle threshold write strobe |
| delay_wr | output | 1 | One-cycle delay write strobe |
| wr_chan | output | 3 | Channel of the latest write |
| wr_value | output | 12 | Value of the latest write |
| tx_data | output | 8 | Reply character |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Transmitter takes tx_data this cycle |

## Verification
The hardest condition to reach is a number that overflows 16 bits but would match a legal value if it wrapped around. The stimulus sends a board number of 65541 to a board at address 5, and a channel of 65536, and expects silence in both cases. Reply backpressure is the other hard case. It is reached by holding `tx_ready` low through a whole presence query and checking that the first reply character stays offered before the transmitter is released. The address input is also moved to 0 and to 200 between lines, to cover the leading-zero suppression in the reply.

// File: rtl/cmd_line_parser.sv
module cmd_line_parser #(
  parameter logic [7:0] FW_VERSION = 8'd23,
  parameter int ARG_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic [7:0]  board_addr,
  output logic        dac_wr,
  output logic        delay_wr,
  output logic [2:0]  wr_chan,
  output logic [11:0] wr_value,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready
);
  localparam int PW = ARG_W + 4;
  localparam logic [ARG_W-1:0] ARG_MAX = '1;
  localparam logic [7:0] VH = FW_VERSION / 8'd100;
  localparam logic [7:0] VT = (FW_VERSION / 8'd10) % 8'd10;
  localparam logic [7:0] VO = FW_VERSION % 8'd10;

  logic [2:0] tok, klen;
  logic intok, bad, busy;
  logic [23:0] kw;
  logic [ARG_W-1:0] arg0, arg1, arg2, cur;
  logic [3:0] step;
  logic [7:0] rep_addr, ch;
  logic skip;

  wire is_term = rx_data == 8'h0D || rx_data == 8'h0A;
  wire is_sp   = rx_data == 8'h20;
  wire is_dig  = rx_data >= 8'h30 && rx_data <= 8'h39;

  always_comb
    case (tok)
      3'd1:    cur = arg0;
      3'd2:    cur = arg1;
      default: cur = arg2;
    endcase

  wire [PW-1:0] prod = {4'b0, cur} * PW'(10) + PW'(rx_data[3:0]);
  wire [ARG_W-1:0] nxt = (prod > PW'(ARG_MAX)) ? ARG_MAX : prod[ARG_W-1:0];
  wire [3:0] ntok = {1'b0, tok} + {3'b0, intok};

  wire line_ok = rx_valid && is_term && klen == 3'd3 && !bad &&
                 arg0 == ARG_W'(board_addr);
  wire dac_go = line_ok && kw == "dac" && ntok == 4'd4 &&
                arg1 <= ARG_W'(7) && arg2 <= ARG_W'(4095);
  wire del_go = line_ok && kw == "del" && ntok == 4'd4 &&
                arg1 <= ARG_W'(7) && arg2 <= ARG_W'(255);
  wire ver_go = line_ok && kw == "ver" && ntok == 4'd2 && !busy;

  wire [7:0] ah = rep_addr / 8'd100;
  wire [7:0] at = (rep_addr / 8'd10) % 8'd10;
  wire [7:0] ao = rep_addr % 8'd10;

  always_comb begin
    skip = 1'b0;
    case (step)
      4'd0:  ch = "v";
      4'd1:  ch = "e";
      4'd2:  ch = "r";
      4'd3:  ch = " ";
      4'd4:  begin ch = 8'h30 + ah; skip = ah == 8'd0; end
      4'd5:  begin ch = 8'h30 + at; skip = ah == 8'd0 && at == 8'd0; end
      4'd6:  ch = 8'h30 + ao;
      4'd7:  ch = " ";
      4'd8:  begin ch = 8'h30 + VH; skip = VH == 8'd0; end
      4'd9:  begin ch = 8'h30 + VT; skip = VH == 8'd0 && VT == 8'd0; end
      4'd10: ch = 8'h30 + VO;
      4'd11: ch = 8'h0D;
      default: ch = 8'h0A;
    endcase
  end

  assign tx_data  = ch;
  assign tx_valid = busy && !skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok <= '0; klen <= '0; intok <= 1'b0; bad <= 1'b0; kw <= '0;
      arg0 <= '0; arg1 <= '0; arg2 <= '0;
      dac_wr <= 1'b0; delay_wr <= 1'b0; wr_chan <= '0; wr_value <= '0;
      busy <= 1'b0; step <= '0; rep_addr <= '0;
    end else begin
      dac_wr   <= dac_go;
      delay_wr <= del_go;
      if (dac_go || del_go) begin
        wr_chan  <= arg1[2:0];
        wr_value <= arg2[11:0];
      end
      if (rx_valid) begin
        if (is_term) begin
          tok <= '0; klen <= '0; intok <= 1'b0; bad <= 1'b0; kw <= '0;
          arg0 <= '0; arg1 <= '0; arg2 <= '0;
        end else if (is_sp) begin
          if (intok) begin
            intok <= 1'b0;
            if (tok != 3'd7) tok <= tok + 3'd1;
          end
        end else begin
          intok <= 1'b1;
          if (tok == 3'd0) begin
            kw <= {kw[15:0], rx_data};
            if (klen != 3'd4) klen <= klen + 3'd1;
          end else if (!is_dig) begin
            bad <= 1'b1;
          end else begin
            case (tok)
              3'd1: arg0 <= nxt;
              3'd2: arg1 <= nxt;
              3'd3: arg2 <= nxt;
              default: ;
            endcase
          end
        end
      end
      if (ver_go) begin
        busy <= 1'b1;
        step <= '0;
        rep_addr <= board_addr;
      end else if (busy && (skip || tx_ready)) begin
        if (step == 4'd12) busy <= 1'b0;
        else step <= step + 4'd1;
      end
    end
  end
endmodule

// File: rtl/cmd_line_parser_chk.sv
module cmd_line_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  rx_data,
  input logic        rx_valid,
  input logic        dac_wr,
  input logic        delay_wr,
  input logic [11:0] wr_value,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready
);
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dac_wr && delay_wr));

  p_dac_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |=> !dac_wr);

  p_del_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    delay_wr |=> !delay_wr);

  p_del_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    delay_wr |-> wr_value <= 12'd255);

  p_after_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr || delay_wr) |->
      $past(rx_valid && (rx_data == 8'h0D || rx_data == 8'h0A)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind cmd_line_parser cmd_line_parser_chk chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .dac_wr(dac_wr), .delay_wr(delay_wr), .wr_value(wr_value),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/cmd_line_parser_test.sv
module cmd_line_parser_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00, board_addr = 8'd5;
  logic rx_valid = 1'b0, tx_ready = 1'b1;
  logic dac_wr, delay_wr, tx_valid;
  logic [2:0] wr_chan;
  logic [11:0] wr_value;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  cmd_line_parser uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .board_addr(board_addr), .dac_wr(dac_wr), .delay_wr(delay_wr),
    .wr_chan(wr_chan), .wr_value(wr_value), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  int dac_n = 0, del_n = 0, rep_n = 0, checks = 0, fails = 0;
  logic [2:0] cap_ch = '0;
  logic [11:0] cap_v = '0;
  logic [127:0] rep = '0;

  always @(posedge clk) begin
    if (dac_wr)   begin dac_n <= dac_n + 1; cap_ch <= wr_chan; cap_v <= wr_value; end
    if (delay_wr) begin del_n <= del_n + 1; cap_ch <= wr_chan; cap_v <= wr_value; end
    if (tx_valid && tx_ready) begin rep <= {rep[119:0], tx_data}; rep_n <= rep_n + 1; end
  end

  localparam logic [79:0] VER5 = {"ver 5 23", 8'h0D, 8'h0A};
  localparam int NV = 22;
  localparam logic [159:0] CMD [NV] = '{
    "dac 5 3 1000", "del 5 7 255", "ver 5", "dac 6 3 1000", "dac 5 8 10",
    "dac 5 0 4096", "del 5 0 256", "dac 5 0 4095", "xyz 5 1 2", "dac 5 1",
    "dac 5 1 2 3", "del 5 1 2a", "ver 65541", "dac 5 65536 7", "del  5   2 0",
    "ver 5 1", "dac 5 0000002 0012", "dacx 5 1 1", "ver 6", "DAC 5 1 1",
    "del 5 0 0", "ver"};
  localparam logic [7:0] TERM [NV] = '{
    8'h0D, 8'h0A, 8'h0D, 8'h0D, 8'h0D, 8'h0D, 8'h0D, 8'h0A, 8'h0D, 8'h0D,
    8'h0D, 8'h0D, 8'h0D, 8'h0D, 8'h0A, 8'h0D, 8'h0D, 8'h0D, 8'h0D, 8'h0D,
    8'h0A, 8'h0D};
  // kind: 0 nothing, 1 threshold write, 2 delay write, 3 version reply
  localparam logic [1:0] KIND [NV] = '{1, 2, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 2, 0, 1, 0, 0, 0, 2, 0};
  localparam logic [2:0] ECH [NV] = '{3, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 2, 0, 0, 0, 0, 0};
  localparam logic [11:0] EVAL [NV] = '{1000, 255, 0, 0, 0, 0, 0, 4095, 0, 0, 0, 0, 0, 0, 0, 0, 12, 0, 0, 0, 0, 0};
  localparam string REQ [NV] = '{"R3", "R4", "R9", "R5", "R6", "R6", "R6", "R6", "R7", "R7",
    "R7", "R7", "R8", "R8", "R2", "R7", "R2", "R7", "R5", "R7", "R4", "R7"};

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send(input logic [159:0] s, input logic [7:0] term);
    for (int i = 19; i >= 0; i--)
      if (s[i*8 +: 8] != 8'h00) put(s[i*8 +: 8]);
    put(term);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int d0, l0, r0;
    logic [1:0] dd, ld;
    logic [2:0] c;
    logic [11:0] v;
    logic ra, rok;
    wait_cyc(3);
    check("R1", {125'd0, dac_wr, delay_wr, tx_valid}, 128'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1", {125'd0, dac_wr, delay_wr, tx_valid}, 128'd0);

    for (int k = 0; k < NV; k++) begin
      d0 = dac_n; l0 = del_n; r0 = rep_n;
      send(CMD[k], TERM[k]);
      wait_cyc(30);
      dd = 2'(dac_n - d0); ld = 2'(del_n - l0);
      c = (dd != 0 || ld != 0) ? cap_ch : 3'd0;
      v = (dd != 0 || ld != 0) ? cap_v : 12'd0;
      ra = rep_n != r0;
      rok = (rep_n - r0 == 10) && rep[79:0] == VER5;
      check(REQ[k], {108'd0, dd, ld, c, v, ra, rok},
            {108'd0, 2'(KIND[k] == 2'd1), 2'(KIND[k] == 2'd2), ECH[k], EVAL[k],
             KIND[k] == 2'd3, KIND[k] == 2'd3});
    end

    // R2: empty lines do nothing
    d0 = dac_n; l0 = del_n; r0 = rep_n;
    put(8'h0D); put(8'h0A); put(8'h0A);
    wait_cyc(20);
    check("R2", 128'(dac_n - d0 + del_n - l0 + rep_n - r0), 128'd0);

    // R9: three-digit address, no leading-zero suppression inside it
    board_addr = 8'd200; r0 = rep_n;
    send("ver 200", 8'h0D);
    wait_cyc(30);
    check("R9", {rep_n - r0 == 12, rep[95:0]}, {1'b1, "ver 200 23", 8'h0D, 8'h0A});

    // R9: address zero gives a single digit
    board_addr = 8'd0; r0 = rep_n;
    send("ver 0", 8'h0A);
    wait_cyc(30);
    check("R9", {rep_n - r0 == 10, rep[79:0]}, {1'b1, "ver 0 23", 8'h0D, 8'h0A});

    // R10: backpressure holds the first character
    board_addr = 8'd5; tx_ready = 1'b0; r0 = rep_n;
    send("ver 5", 8'h0D);
    wait_cyc(4);
    check("R10", {tx_valid, tx_data}, {1'b1, "v"});
    wait_cyc(6);
    check("R10", {tx_valid, tx_data, rep_n == r0}, {1'b1, "v", 1'b1});
    tx_ready = 1'b1;
    wait_cyc(30);
    check("R10", {rep_n - r0 == 10, rep[79:0]}, {1'b1, VER5});

    // R3: write right after reply, strobe value check at port
    d0 = dac_n;
    send("dac 5 6 7", 8'h0D);
    wait_cyc(10);
    check("R3", {dac_n - d0, cap_ch, cap_v}, {32'd1, 3'd6, 12'd7});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule